// File: doc/BRIEF.md
# Data Clock and Request Strobe Generator

This block runs on the fast converter clock. From it the block derives a slower data clock for an external data source, a sampling clock at the same rate for input capture, and a request strobe that asks the source for each new data word. A 3-bit divide code selects the data clock period as 16, 32 or 64 converter cycles (base period 16 times N, with N equal to 1, 2 or 4). Code 0 stops the clock. All other codes are rejected and flagged.

The request strobe is paced by a fractional accumulator. Once per data clock period it adds a step of N·P and compares the sum against a threshold of I·Q. I is the interpolation factor (1 to 64) and P/Q is the rate-conversion ratio (0.5 to 1.0). The strobe therefore averages step/threshold requests per data clock period, which works out to the symbol rate. Each individual pulse is one full data clock period wide and begins on a data clock rising edge, so a source that times itself from the data clock always sees the request settled.

Top module: `dclkgen_top`

## Requirements
- R1: With a legal divide code (binary 001 = N 1, 010 = N 2, 100 = N 4), `dataClk` has a period of 16·N converter cycles. It is high for the first half of each period and low for the second half.
- R2: With divide code 000, `dataClk`, `sampClk` and `reqPulse` stay low and `codeErr` stays low.
- R3: `sampClk` has the same period as `dataClk`. It is high from one quarter to three quarters of each data clock period, so it rises a quarter period after `dataClk` rises.
- R4: Divide codes 011, 101, 110 and 111 raise `codeErr` in the first cycle after they are applied. While such a code is applied, `dataClk`, `sampClk` and `reqPulse` stay low.
- R5: `reqPulse` changes only in the converter cycle in which `dataClk` rises, or when the clock is stopped. It keeps its value for a whole data clock period.
- R6: Let step = N·P and threshold = I·Q, and count data clock periods p = 1, 2, ... from the start of the clock. `reqPulse` is high in period p exactly when floor(p·step/threshold) > floor((p−1)·step/threshold). When step ≥ threshold, it is high in every period.
- R7: When the divide code changes, `dataClk`, `sampClk` and `reqPulse` are low in the next cycle. In the cycle after that, a fresh data clock period starts with a cleared accumulator.
- R8: While reset is held, and immediately after it is released, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divCode | input | 3 | Data clock divide code |
| interp | input | IW (7) | Interpolation factor I, 1 to 64 |
| rateP | input | RW (8) | Rate ratio numerator P |
| rateQ | input | RW (8) | Rate ratio denominator Q |
| dataClk | output | 1 | Divided data clock |
| sampClk | output | 1 | Quarter-period-delayed sampling clock |
| reqPulse | output | 1 | Data word request, one data clock period wide |
| codeErr | output | 1 | Unsupported divide code applied |

## Verification
A wrong divider count shows up within one data clock period as a high or low phase of the wrong length on `dataClk` or `sampClk`. A corrupted accumulator appears as a request in the wrong period, which becomes visible as soon as the expected crossing pattern diverges. For small ratios this can take up to threshold/step periods, so each setting runs for 24 periods and also has its total request count checked. A restart that is not clean is exposed in the cycle after a code change, because a high `dataClk` or `reqPulse` is visible there, and again in the first period, which must follow the pattern from a cleared accumulator.

// File: rtl/dclkgen_pkg.sv
`timescale 1ns/1ps
package dclkgen_pkg;

  // strobes passed from control to the accumulator datapath
  typedef struct packed {
    logic       stop;   // clock halted or restarting: clear state
    logic       rise;   // data clock period begins at this edge
    logic [1:0] shift;  // log2 of divide factor N
  } ctrlStrobe_t;

  function automatic logic codeLegal(input logic [2:0] c);
    return (c == 3'd1) || (c == 3'd2) || (c == 3'd4);
  endfunction

  function automatic logic [1:0] codeShift(input logic [2:0] c);
    case (c)
      3'd2:    return 2'd1;
      3'd4:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/dclkgen_ctrl.sv
`timescale 1ns/1ps
module dclkgen_ctrl
  import dclkgen_pkg::*;
#(
  parameter int BASE_DIV = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  divCode,
  output ctrlStrobe_t str,
  output logic        dataClk,
  output logic        sampClk,
  output logic        codeErr
);

  localparam int CW = $clog2(BASE_DIV * 4) + 1;
  localparam logic [CW-1:0] BASE = CW'(BASE_DIV);

  logic [2:0]    codeQ;
  logic [CW-1:0] cnt;
  logic          runQ;
  logic          dclkQ;
  logic          sclkQ;

  logic          chg;
  logic          legalQ;
  logic [1:0]    shift;
  logic [CW-1:0] len;
  logic [CW-1:0] half;
  logic [CW-1:0] qtr;
  logic          stop;
  logic          rise;
  logic [CW-1:0] cntNext;

  always_comb begin
    chg     = (divCode != codeQ);
    legalQ  = codeLegal(codeQ);
    shift   = codeShift(codeQ);
    len     = BASE << shift;
    half    = len >> 1;
    qtr     = len >> 2;
    stop    = chg || !legalQ;
    rise    = !stop && (!runQ || (cnt == len - CW'(1)));
    cntNext = rise ? '0 : cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codeQ <= '0;
      cnt   <= '0;
      runQ  <= 1'b0;
      dclkQ <= 1'b0;
      sclkQ <= 1'b0;
    end else begin
      codeQ <= divCode;
      if (stop) begin
        cnt   <= '0;
        runQ  <= 1'b0;
        dclkQ <= 1'b0;
        sclkQ <= 1'b0;
      end else begin
        cnt   <= cntNext;
        runQ  <= 1'b1;
        dclkQ <= (cntNext < half);
        sclkQ <= (cntNext >= qtr) && (cntNext < half + qtr);
      end
    end
  end

  assign str     = '{stop: stop, rise: rise, shift: shift};
  assign dataClk = dclkQ;
  assign sampClk = sclkQ;
  assign codeErr = !legalQ && (codeQ != 3'd0);

  // R4: a rejected code keeps both clocks low
  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    codeErr |-> (!dataClk && !sampClk));

  // R7: a code change silences the data clock on the next cycle
  p_restart_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (divCode != codeQ) |=> !dataClk);

  // R1: data clock rises only at a period boundary or a fresh start
  p_rise_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataClk) |-> (cnt == '0));

  // R3: sampling clock rises inside the data clock high phase
  p_samp_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sampClk) |-> dataClk);

endmodule

// File: rtl/dclkgen_accum.sv
`timescale 1ns/1ps
module dclkgen_accum
  import dclkgen_pkg::*;
#(
  parameter int RW = 8,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrlStrobe_t   str,
  input  logic [IW-1:0] interp,
  input  logic [RW-1:0] rateP,
  input  logic [RW-1:0] rateQ,
  output logic          reqPulse
);

  localparam int AW = RW + IW + 1;

  logic [AW-1:0] accQ;
  logic          reqQ;
  logic [AW-1:0] step;
  logic [AW-1:0] thr;
  logic [AW-1:0] sum;

  always_comb begin
    step = AW'(rateP) << str.shift;
    thr  = AW'(interp) * AW'(rateQ);
    sum  = accQ + step;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accQ <= '0;
      reqQ <= 1'b0;
    end else if (str.stop) begin
      accQ <= '0;
      reqQ <= 1'b0;
    end else if (str.rise) begin
      if (step >= thr) begin
        accQ <= '0;
        reqQ <= 1'b1;
      end else if (sum >= thr) begin
        accQ <= sum - thr;
        reqQ <= 1'b1;
      end else begin
        accQ <= sum;
        reqQ <= 1'b0;
      end
    end
  end

  assign reqPulse = reqQ;

  // R5: request only moves on a period start or a stop
  p_req_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reqQ) |-> $past(str.rise || str.stop));

  // R7: a stop clears the request on the following cycle
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    str.stop |=> !reqQ);

endmodule

// File: rtl/dclkgen_top.sv
`timescale 1ns/1ps
module dclkgen_top
  import dclkgen_pkg::*;
#(
  parameter int BASE_DIV = 16,
  parameter int RW       = 8,
  parameter int IW       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    divCode,
  input  logic [IW-1:0] interp,
  input  logic [RW-1:0] rateP,
  input  logic [RW-1:0] rateQ,
  output logic          dataClk,
  output logic          sampClk,
  output logic          reqPulse,
  output logic          codeErr
);

  ctrlStrobe_t str;

  dclkgen_ctrl #(.BASE_DIV(BASE_DIV)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .divCode (divCode),
    .str     (str),
    .dataClk (dataClk),
    .sampClk (sampClk),
    .codeErr (codeErr)
  );

  dclkgen_accum #(.RW(RW), .IW(IW)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .str      (str),
    .interp   (interp),
    .rateP    (rateP),
    .rateQ    (rateQ),
    .reqPulse (reqPulse)
  );

  // R2/R4: no request while the clock is idle
  p_req_needs_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (codeErr || (divCode == 3'd0 && $past(divCode) == 3'd0)) |=> !reqPulse);

endmodule

// File: tb/tb_dclkgen_top.sv
`timescale 1ns/1ps
module tb_dclkgen_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] divCode = 3'd0;
  logic [6:0] interp = 7'd1;
  logic [7:0] rateP = 8'd1;
  logic [7:0] rateQ = 8'd1;
  logic       dataClk, sampClk, reqPulse, codeErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  dclkgen_top dut (
    .clk(clk), .rst_n(rst_n), .divCode(divCode), .interp(interp),
    .rateP(rateP), .rateQ(rateQ), .dataClk(dataClk), .sampClk(sampClk),
    .reqPulse(reqPulse), .codeErr(codeErr)
  );

  // columns: code, I, P, Q, expected requests over PERIODS periods
  localparam int NVEC    = 6;
  localparam int PERIODS = 24;
  localparam int VEC [NVEC][5] = '{
    '{1,  3,   1,   1,  8},
    '{2,  5,   3,   4,  7},
    '{4, 64, 255, 255,  1},
    '{1,  1,   1,   1, 24},
    '{4,  2, 128, 255, 24},
    '{2,  7,   2,   3,  4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // restart into code, then compare nPer periods against the model
  task automatic runCfg(input int code, input int iv, input int pv, input int qv,
                        input int expPulses, input int nPer, input bit fromStop);
    int n, len, step, thr, m, badD, badS, badR, pulses;
    n    = (code == 4) ? 4 : code;
    len  = 16 * n;
    step = n * pv;
    thr  = iv * qv;
    @(negedge clk);
    interp = 7'(iv); rateP = 8'(pv); rateQ = 8'(qv);
    if (fromStop) begin
      divCode = 3'd0;
      @(negedge clk);
    end
    divCode = 3'(code);
    @(negedge clk);
    chk(!dataClk && !sampClk && !reqPulse, "R7 quiet after code change",
        {dataClk, sampClk, reqPulse}, 0);
    m = len * nPer;
    badD = 0; badS = 0; badR = 0; pulses = 0;
    for (int i = 0; i < m; i++) begin
      int c, p;
      bit eD, eS, eR;
      @(negedge clk);
      c  = i % len;
      p  = i / len;
      eD = (c < len / 2);
      eS = (c >= len / 4) && (c < 3 * len / 4);
      eR = (step >= thr) ? 1'b1 : (((p + 1) * step / thr) > (p * step / thr));
      if (dataClk !== eD) badD++;
      if (sampClk !== eS) badS++;
      if (reqPulse !== eR) badR++;
      if (c == 0 && reqPulse) pulses++;
    end
    chk(badD == 0, "R1 data clock period/duty", badD, 0);
    chk(badS == 0, "R3 sampling clock phase", badS, 0);
    chk(badR == 0, "R5 R6 request per period", badR, 0);
    if (expPulses >= 0) chk(pulses == expPulses, "R6 request count", pulses, expPulses);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!dataClk && !sampClk && !reqPulse && !codeErr, "R8 reset state",
        {dataClk, sampClk, reqPulse, codeErr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dataClk && !sampClk && !reqPulse && !codeErr, "R8 after release",
        {dataClk, sampClk, reqPulse, codeErr}, 0);

    // R2: code 0 keeps everything idle
    begin
      int bad = 0;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        if (dataClk || sampClk || reqPulse || codeErr) bad++;
      end
      chk(bad == 0, "R2 code 0 idle", bad, 0);
    end

    // vector table
    for (int v = 0; v < NVEC; v++)
      runCfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], PERIODS, 1'b1);

    // R4: rejected codes
    foreach (VEC[0][k]) begin end
    for (int k = 0; k < 4; k++) begin
      int code, bad;
      code = (k == 0) ? 3 : 4 + k;
      @(negedge clk);
      divCode = 3'(code);
      @(negedge clk);
      chk(codeErr === 1'b1, "R4 codeErr raised", codeErr, 1);
      bad = 0;
      for (int i = 0; i < 70; i++) begin
        @(negedge clk);
        if (dataClk || sampClk || reqPulse || !codeErr) bad++;
      end
      chk(bad == 0, "R4 outputs held low", bad, 0);
    end

    // R7: change code mid-run, then check a clean start
    runCfg(4, 5, 3, 4, -1, 1, 1'b1);
    repeat (21) @(negedge clk);
    runCfg(1, 3, 1, 1, 4, 12, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule